// File: doc/BRIEF.md
# Condition Code Execute Predicate

This block decides, in a single combinational step, whether an instruction is allowed to take effect. It looks at the instruction's 4-bit condition field and at the four processor status flags: negative, zero, carry and overflow. It drives one execute-enable bit. Downstream logic uses that bit to gate both the register write-back and the flag update of the instruction. The block holds no state, and its outputs follow its inputs within the same cycle.

The sixteen codes form eight pairs. The even member of each pair passes on a base condition, and the odd member passes on its complement. Four base conditions read a single flag: zero, carry, negative and overflow. Three base conditions combine flags to give unsigned-higher, signed greater-or-equal and signed greater-than. The last pair holds the unconditional code and the reserved code. The reserved code never executes and is reported on its own output, so that decode can raise an undefined-instruction event.

Top module: `cond_exec_unit`

## Requirements
- R1: Code 0000 executes exactly when Z is 1, and code 0001 executes exactly when Z is 0.
- R2: Code 0010 executes exactly when C is 1, and code 0011 executes exactly when C is 0.
- R3: Code 0100 executes exactly when N is 1, and code 0101 executes exactly when N is 0.
- R4: Code 0110 executes exactly when V is 1, and code 0111 executes exactly when V is 0.
- R5: Code 1000 (unsigned higher) executes exactly when C is 1 and Z is 0, and code 1001 executes exactly when that is false.
- R6: Code 1010 (signed greater or equal) executes exactly when N equals V, and code 1011 executes exactly when N differs from V.
- R7: Code 1100 (signed greater than) executes exactly when Z is 0 and N equals V, and code 1101 executes exactly when that is false.
- R8: Code 1110 executes for every one of the 16 flag combinations.
- R9: Code 1111 holds execute-enable at 0 and drives the reserved output to 1 for every flag combination, and every other code drives the reserved output to 0.
- R10: For each code pair 2k and 2k+1 with k from 0 to 6, the two codes give opposite execute-enable values under the same flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cond_code | input | 4 | Condition field of the instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| exec_en | output | 1 | 1 when the instruction is allowed to execute |
| cond_reserved | output | 1 | 1 when the condition field holds the reserved code |

## Verification
Each code is applied under all sixteen flag combinations. For a single-flag pair, the sweep shows that the code follows only its own flag and ignores the other three. For HI/LS, the sweep separates the conjunction of carry and not-zero from either flag taken alone. For GE/LT and GT/LE, the cases where N and V agree and disagree, with Z set or clear, separate a correct signed compare from one that reads N or V only. A dedicated pass over the last pair confirms that the unconditional code and the reserved code do not depend on the flags, and that the reserved output stays low on every other code.

// File: rtl/cond_pred_pkg.sv
package cond_pred_pkg;

    // Width of the condition field and the pair structure derived from it.
    localparam int COND_W     = 4;
    localparam int NUM_CODES  = 2 ** COND_W;
    localparam int NUM_PAIRS  = NUM_CODES / 2;
    // The last pair (always / reserved) carries no flag term.
    localparam int FLAG_PAIRS = NUM_PAIRS - 1;

    // Index of each flag-driven base term; the code pair is 2*index.
    localparam int TERM_ZERO  = 0;
    localparam int TERM_CARRY = 1;
    localparam int TERM_NEG   = 2;
    localparam int TERM_OVF   = 3;
    localparam int TERM_UHI   = 4;
    localparam int TERM_SGE   = 5;
    localparam int TERM_SGT   = 6;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } status_flags_t;

endpackage

// File: rtl/cond_flag_terms.sv
module cond_flag_terms
    import cond_pred_pkg::*;
#(
    parameter int N_TERMS = FLAG_PAIRS
) (
    input  status_flags_t        flags,
    output logic [N_TERMS-1:0]   term_true
);

    logic signs_agree;

    always_comb begin
        signs_agree = ~(flags.neg ^ flags.ovf);
        term_true   = '0;
        term_true[TERM_ZERO]  = flags.zero;
        term_true[TERM_CARRY] = flags.carry;
        term_true[TERM_NEG]   = flags.neg;
        term_true[TERM_OVF]   = flags.ovf;
        term_true[TERM_UHI]   = flags.carry & ~flags.zero;
        term_true[TERM_SGE]   = signs_agree;
        term_true[TERM_SGT]   = ~flags.zero & signs_agree;
    end

endmodule

// File: rtl/cond_pair_mux.sv
module cond_pair_mux #(
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0]            code,
    input  logic [2**(CODE_W-1)-2:0]     term_true,
    output logic                         pass,
    output logic                         reserved
);

    localparam int N_PAIRS  = 2 ** (CODE_W - 1);
    localparam int LAST     = N_PAIRS - 1;
    localparam int N_CODES  = 2 * N_PAIRS;

    logic [N_CODES-1:0] code_pass;

    generate
        for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
            if (p == LAST) begin : g_fixed
                // Even member: unconditional; odd member: reserved, never runs.
                assign code_pass[2*p]   = 1'b1;
                assign code_pass[2*p+1] = 1'b0;
            end else begin : g_flag
                assign code_pass[2*p]   = term_true[p];
                assign code_pass[2*p+1] = ~term_true[p];
            end
        end
    endgenerate

    assign pass     = code_pass[code];
    assign reserved = (code == {CODE_W{1'b1}});

endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
    import cond_pred_pkg::*;
(
    input  logic [3:0] cond_code,
    input  logic       flag_n,
    input  logic       flag_z,
    input  logic       flag_c,
    input  logic       flag_v,
    output logic       exec_en,
    output logic       cond_reserved
);

    status_flags_t           flags;
    logic [FLAG_PAIRS-1:0]   term_true;
    logic                    code_pass;
    logic                    code_rsv;

    assign flags = '{neg: flag_n, zero: flag_z, carry: flag_c, ovf: flag_v};

    cond_flag_terms #(
        .N_TERMS (FLAG_PAIRS)
    ) u_terms (
        .flags     (flags),
        .term_true (term_true)
    );

    cond_pair_mux #(
        .CODE_W (COND_W)
    ) u_mux (
        .code      (cond_code),
        .term_true (term_true),
        .pass      (code_pass),
        .reserved  (code_rsv)
    );

    assign exec_en       = code_pass & ~code_rsv;
    assign cond_reserved = code_rsv;

endmodule

// File: rtl/cond_exec_unit_chk.sv
module cond_exec_unit_chk (
    input logic [3:0] cond_code,
    input logic       flag_n,
    input logic       flag_z,
    input logic       flag_c,
    input logic       flag_v,
    input logic       exec_en,
    input logic       cond_reserved
);

    always_comb begin
        if (cond_code[3:1] == 3'd0)
            assert_zero_pair_R1: assert (exec_en == (flag_z ^ cond_code[0]))
                else $error("zero pair mismatch");
        if (cond_code[3:1] == 3'd1)
            assert_carry_pair_R2: assert (exec_en == (flag_c ^ cond_code[0]))
                else $error("carry pair mismatch");
        if (cond_code[3:1] == 3'd2)
            assert_neg_pair_R3: assert (exec_en == (flag_n ^ cond_code[0]))
                else $error("negative pair mismatch");
        if (cond_code[3:1] == 3'd3)
            assert_ovf_pair_R4: assert (exec_en == (flag_v ^ cond_code[0]))
                else $error("overflow pair mismatch");
        if (cond_code == 4'b1000 && exec_en)
            assert_uhi_needs_carry_R5: assert (flag_c && !flag_z)
                else $error("higher executed without carry-set zero-clear");
        if (cond_code == 4'b1010)
            assert_sge_sign_R6: assert (exec_en == (flag_n == flag_v))
                else $error("signed ge mismatch");
        if (cond_code == 4'b1100 && flag_z)
            assert_sgt_zero_blocks_R7: assert (!exec_en)
                else $error("signed gt executed with zero set");
        if (cond_code == 4'b1110)
            assert_always_runs_R8: assert (exec_en)
                else $error("unconditional code blocked");
        if (cond_reserved)
            assert_reserved_blocks_R9: assert (!exec_en && cond_code == 4'b1111)
                else $error("reserved code misreported");
    end

endmodule

bind cond_exec_unit cond_exec_unit_chk u_chk (.*);

// File: tb/cond_exec_unit_tb.sv
module cond_exec_unit_tb;

    logic       clk;
    logic [3:0] cond_code;
    logic       flag_n, flag_z, flag_c, flag_v;
    logic       exec_en, cond_reserved;

    int checks;
    int errors;
    int cycles;

    cond_exec_unit u_dut (
        .cond_code     (cond_code),
        .flag_n        (flag_n),
        .flag_z        (flag_z),
        .flag_c        (flag_c),
        .flag_v        (flag_v),
        .exec_en       (exec_en),
        .cond_reserved (cond_reserved)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycles=%0d expected <=20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Reference model written from the requirement text.
    function automatic logic ref_exec(input logic [3:0] c, input logic n,
                                      input logic z, input logic cy, input logic v);
        case (c)
            4'd0:  return z;                    // R1
            4'd1:  return !z;                   // R1
            4'd2:  return cy;                   // R2
            4'd3:  return !cy;                  // R2
            4'd4:  return n;                    // R3
            4'd5:  return !n;                   // R3
            4'd6:  return v;                    // R4
            4'd7:  return !v;                   // R4
            4'd8:  return cy && !z;             // R5
            4'd9:  return !cy || z;             // R5
            4'd10: return n == v;               // R6
            4'd11: return n != v;               // R6
            4'd12: return !z && (n == v);       // R7
            4'd13: return z || (n != v);        // R7
            4'd14: return 1'b1;                 // R8
            default: return 1'b0;               // R9
        endcase
    endfunction

    task automatic apply(input logic [3:0] c, input logic [3:0] f);
        @(negedge clk);
        cond_code = c;
        {flag_n, flag_z, flag_c, flag_v} = f;
        #1;
    endtask

    task automatic check_one(input string req, input logic [3:0] c, input logic [3:0] f);
        logic exp_en, exp_rsv;
        apply(c, f);
        exp_en  = ref_exec(c, f[3], f[2], f[1], f[0]);
        exp_rsv = (c == 4'b1111);
        checks = checks + 1;
        if (exec_en !== exp_en || cond_reserved !== exp_rsv) begin
            errors = errors + 1;
            $display("FAIL %s code=%b nzcv=%b: actual en=%b rsv=%b expected en=%b rsv=%b",
                     req, c, f, exec_en, cond_reserved, exp_en, exp_rsv);
        end
    endtask

    task automatic sweep_code(input string req, input logic [3:0] c);
        for (int f = 0; f < 16; f++) check_one(req, c, 4'(f));
    endtask

    task automatic test_idle_state;
        // Initial state with all inputs cleared: zero flag clear, so EQ must not run.
        check_one("R1 idle", 4'd0, 4'b0000);
    endtask

    task automatic test_single_flag_pairs;
        sweep_code("R1", 4'd0);  sweep_code("R1", 4'd1);
        sweep_code("R2", 4'd2);  sweep_code("R2", 4'd3);
        sweep_code("R3", 4'd4);  sweep_code("R3", 4'd5);
        sweep_code("R4", 4'd6);  sweep_code("R4", 4'd7);
    endtask

    task automatic test_compound_pairs;
        sweep_code("R5", 4'd8);  sweep_code("R5", 4'd9);
        sweep_code("R6", 4'd10); sweep_code("R6", 4'd11);
        sweep_code("R7", 4'd12); sweep_code("R7", 4'd13);
    endtask

    task automatic test_fixed_pair;
        sweep_code("R8", 4'd14);
        sweep_code("R9", 4'd15);
    endtask

    task automatic test_complement_R10;
        for (int k = 0; k < 7; k++) begin
            for (int f = 0; f < 16; f++) begin
                logic e0, e1;
                apply(4'(2*k), 4'(f));
                e0 = exec_en;
                apply(4'(2*k+1), 4'(f));
                e1 = exec_en;
                checks = checks + 1;
                if (e0 === e1 || $isunknown({e0, e1})) begin
                    errors = errors + 1;
                    $display("FAIL R10 pair=%0d nzcv=%b: actual even=%b odd=%b expected opposite",
                             k, 4'(f), e0, e1);
                end
            end
        end
    endtask

    initial begin
        checks = 0; errors = 0; cycles = 0;
        cond_code = 4'd0;
        {flag_n, flag_z, flag_c, flag_v} = 4'b0000;
        test_idle_state();
        test_single_flag_pairs();
        test_compound_pairs();
        test_fixed_pair();
        test_complement_R10();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule